// File: doc/BRIEF.md
# Serial EEPROM page write buffer

This block sits behind the serial front end of a small byte-wide EEPROM model and handles the array side of a page write. A start strobe with a start address opens a write command. From then on, each byte-valid strobe drops one data byte into a 16-byte page latch. The latch position advances only within the current page. When the chip is deselected at the close of a whole byte, the loaded bytes are committed to the behavioural array as one self-timed write cycle. A separate allow input, driven by the protection logic, gates that commit.

While the write cycle runs, the block raises a busy flag and ignores every command input. It pushes the loaded bytes through its array write port, one latch slot per clock. It then drops busy and gives a one-cycle done pulse. Array reads are served only while no write cycle is running. The cycle length is a parameter counted in clock cycles, so a simulation can use a short value.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy, done, rdValid and memWrEn are all 0, and every array byte reads as 8'hFF.
- R2: A wrStart while no write cycle runs captures wrAddr. Bits [8:4] select the page and bits [3:0] the first offset. The n-th byte that follows goes to offset (first offset + n) mod 16 of that page.
- R3: The offset wraps from 15 to 0 inside the same page and never carries into the page number. A later byte at an offset already loaded replaces the earlier one.
- R4: A commit writes only the offsets loaded since the last wrStart. Every other location, in that page or elsewhere, keeps its old contents.
- R5: A deselect raised with bitAligned=1 and commitAllow=1, when at least one byte has been loaded, starts a write cycle: busy is 1 from the next clock. A byteValid in the same cycle as that deselect is loaded and included in the commit. A single byte is a valid write.
- R6: A deselect with bitAligned=0, or with no byte loaded, writes nothing and ends the command. byteValid strobes after it are ignored until the next wrStart.
- R7: A deselect with commitAllow=0 writes nothing and ends the command.
- R8: busy stays 1 for exactly WRITE_CYCLES clocks (default 40, at least 16). done is 1 for exactly the one clock after busy falls.
- R9: While busy is 1, wrStart, byteValid and deselect have no effect. The cycle runs to completion, and bytes sent during it are not stored.
- R10: A rdReq made while busy is 0 gives rdValid=1 one clock later, with rdData equal to the byte at rdAddr. A rdReq made while busy is 1 gives rdValid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Opens a write command at wrAddr |
| wrAddr | input | 9 | Start address: page in [8:4], offset in [3:0] |
| byteValid | input | 1 | One data byte is complete |
| byteData | input | 8 | Data byte |
| bitAligned | input | 1 | Serial bit count is on a byte boundary |
| deselect | input | 1 | Chip-deselect event, one clock |
| commitAllow | input | 1 | Protection logic allows the commit |
| rdReq | input | 1 | Array read request |
| rdAddr | input | 9 | Array read address |
| rdData | output | 8 | Read data |
| rdValid | output | 1 | rdData is valid |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-clock pulse after the write cycle |
| memWrEn | output | 1 | Array write port enable |
| memWrAddr | output | 9 | Array write port address |
| memWrData | output | 8 | Array write port data |

## Verification
Two functions can land in the same clock: loading a byte into the latch and accepting the deselect that commits the latch. The bench raises byteValid and deselect together as the final byte of a command, and also follows a byte directly with a deselect. It then reads the page back and expects the final byte in place.

A second collision pairs a read request with the last busy clock and with the done clock. There the bench expects rdValid to stay low in the first case and to rise in the second.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  parameter int PAGE_BYTES = 16;
  parameter int OFF_W      = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_BUSY} pgwState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             capture;   // new command: take page and offset
    logic             load;      // store byteData at current offset
    logic             sweep;     // commit sweep slot active
    logic [OFF_W-1:0] sweepIdx;  // latch slot presented to the array
    logic             blockRead; // write cycle running
  } pgwStrobe_t;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic       byteValid,
  input  logic       deselect,
  input  logic       bitAligned,
  input  logic       commitAllow,
  input  logic       anyLoaded,
  output pgwStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

  pgwState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             commitOk;

  assign busy     = (state == ST_BUSY);
  assign commitOk = bitAligned && commitAllow && (anyLoaded || byteValid);

  always_comb begin
    strb           = '0;
    strb.capture   = wrStart && !deselect && (state != ST_BUSY);
    strb.load      = byteValid && (state == ST_COLLECT);
    strb.sweep     = busy && (cnt < SWEEP_END);
    strb.sweepIdx  = cnt[OFF_W-1:0];
    strb.blockRead = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wrStart) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (deselect) begin
            cnt   <= '0;
            state <= commitOk ? ST_BUSY : ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cnt == LAST_CNT) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != LAST_CNT) |=> busy); // R8
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(busy))); // R8
  AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(deselect && bitAligned && commitAllow)); // R5
  AST_BUSY_IGNORES_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != LAST_CNT && deselect) |=> busy); // R9
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              anyLoaded,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [DATA_W-1:0]     pageLatch [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [PAGE_W-1:0]     pageSel;
  logic [OFF_W-1:0]      offset;
  logic [DATA_W-1:0]     mem [DEPTH];

  assign anyLoaded = |loadedMask;
  assign memWrEn   = strb.sweep && loadedMask[strb.sweepIdx];
  assign memWrAddr = {pageSel, strb.sweepIdx};
  assign memWrData = pageLatch[strb.sweepIdx];

  // Page latch and fill tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadedMask <= '0;
      pageSel    <= '0;
      offset     <= '0;
    end else if (strb.capture) begin
      loadedMask <= '0;
      pageSel    <= wrAddr[ADDR_W-1:OFF_W];
      offset     <= wrAddr[OFF_W-1:0];
    end else if (strb.load) begin
      loadedMask[offset] <= 1'b1;
      offset             <= offset + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.load && offset == OFF_W'(gi)) pageLatch[gi] <= byteData;
      end
    end
  endgenerate

  // Behavioural array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (memWrEn) begin
      mem[memWrAddr] <= memWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdReq && !strb.blockRead;
      rdData  <= mem[rdAddr];
    end
  end

  AST_OFFSET_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.capture) |=> offset == $past(offset) + 1'b1); // R3
  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(pageSel)); // R3
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdReq && !strb.blockRead)); // R10
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              bitAligned,
  input  logic              deselect,
  input  logic              commitAllow,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              done,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  pgwStrobe_t strb;
  logic       anyLoaded;

  pgw_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .byteValid(byteValid),
    .deselect(deselect), .bitAligned(bitAligned), .commitAllow(commitAllow),
    .anyLoaded(anyLoaded), .strb(strb), .busy(busy), .done(done)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .byteData(byteData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .anyLoaded(anyLoaded), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy); // R4
endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;
  localparam int W = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStart = 0, byteValid = 0, bitAligned = 1, deselect = 0;
  logic       commitAllow = 1, rdReq = 0;
  logic [8:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] byteData = 0;
  logic [7:0] rdData;
  logic       rdValid, busy, done, memWrEn;
  logic [8:0] memWrAddr;
  logic [7:0] memWrData;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0] refMem [512];
  logic [7:0] mLatch [16];
  logic [15:0] mMask;
  logic [4:0]  mPage;
  logic [3:0]  mOff;
  bit          mOpen;

  always #10 clk = ~clk;

  eeprom_page_writer #(.WRITE_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrAddr(wrAddr),
    .byteValid(byteValid), .byteData(byteData), .bitAligned(bitAligned),
    .deselect(deselect), .commitAllow(commitAllow), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .busy(busy),
    .done(done), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData)
  );

  function automatic logic [8:0] slotAddr(logic [4:0] pg, logic [3:0] off);
    return {pg, off};
  endfunction

  function automatic bit commitExpected(bit aligned, bit allow, logic [15:0] mask);
    return aligned && allow && (mask != 0);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startCmd(logic [8:0] a);
    @(negedge clk);
    wrStart = 1; wrAddr = a;
    @(negedge clk);
    wrStart = 0;
    if (!busy) begin
      mOpen = 1; mMask = 0; mPage = a[8:4]; mOff = a[3:0];
    end
  endtask

  task automatic modelLoad(logic [7:0] d);
    if (mOpen) begin
      mLatch[mOff] = d; mMask[mOff] = 1'b1; mOff = mOff + 1'b1;
    end
  endtask

  task automatic sendByte(logic [7:0] d);
    byteValid = 1; byteData = d;
    @(negedge clk);
    byteValid = 0;
    modelLoad(d);
  endtask

  // Returns through the checks; dsel optionally merged with a last byte
  task automatic finishCmd(bit aligned, bit allow, bit withByte, logic [7:0] d, string req);
    bit expCommit;
    int cyc;
    if (withByte) begin byteValid = 1; byteData = d; modelLoad(d); end
    deselect = 1; bitAligned = aligned; commitAllow = allow;
    expCommit = mOpen && commitExpected(aligned, allow, mMask);
    @(negedge clk);
    deselect = 0; byteValid = 0; bitAligned = 1; commitAllow = 1;
    check({req, " busy after deselect"}, busy, expCommit);
    if (expCommit) begin
      for (int k = 0; k < 16; k++)
        if (mMask[k]) refMem[slotAddr(mPage, 4'(k))] = mLatch[k];
      cyc = 0;
      while (busy && cyc < W + 5) begin cyc++; @(negedge clk); end
      check("R8 busy length", cyc, W);
      check("R8 done after busy", done, 1);
      @(negedge clk);
      check("R8 done one clock", done, 0);
    end
    mOpen = 0;
  endtask

  task automatic readCheck(logic [8:0] a, string req);
    rdReq = 1; rdAddr = a;
    @(negedge clk);
    rdReq = 0;
    check({req, " rdValid"}, rdValid, 1);
    check({req, " rdData"}, rdData, refMem[a]);
  endtask

  task automatic pageCheck(logic [4:0] pg, string req);
    for (int k = 0; k < 16; k++) readCheck(slotAddr(pg, 4'(k)), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    int n;
    int busyCnt;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
    mOpen = 0; mMask = 0; mPage = 0; mOff = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rdValid", rdValid, 0);
    check("R1 memWrEn", memWrEn, 0);
    readCheck(9'h0A5, "R1 erased");

    // R5 single byte, R2 placement, R4 neighbours untouched
    startCmd(9'h123);
    finishCmd(1, 1, 1, 8'h5A, "R5");
    pageCheck(5'h12, "R2 R4 single byte");

    // R3 wrap from offset 14 with 18 bytes: overwrite of 14,15
    startCmd(9'h03E);
    for (int k = 0; k < 17; k++) sendByte(8'(8'h10 + k));
    finishCmd(1, 1, 1, 8'hEE, "R3");
    pageCheck(5'h03, "R3 wrap");
    readCheck(9'h040, "R3 no carry");

    // R6 unaligned deselect, then bytes after are ignored
    startCmd(9'h050);
    sendByte(8'hA1); sendByte(8'hA2);
    finishCmd(0, 1, 0, 8'h00, "R6 unaligned");
    sendByte(8'hB7);
    finishCmd(1, 1, 0, 8'h00, "R6 bytes after abandon");
    pageCheck(5'h05, "R6 nothing written");

    // R6 deselect with no byte loaded
    startCmd(9'h060);
    finishCmd(1, 1, 0, 8'h00, "R6 empty");
    readCheck(9'h060, "R6 empty");

    // R7 allow low
    startCmd(9'h070);
    sendByte(8'hC3);
    finishCmd(1, 0, 0, 8'h00, "R7");
    readCheck(9'h070, "R7 no write");

    // R9 and R10: inputs during busy
    startCmd(9'h088);
    sendByte(8'h11); sendByte(8'h22);
    deselect = 1;
    @(negedge clk);
    deselect = 0;
    for (int k = 0; k < 16; k++)
      if (mMask[k]) refMem[slotAddr(mPage, 4'(k))] = mLatch[k];
    mOpen = 0;
    check("R9 busy", busy, 1);
    wrStart = 1; wrAddr = 9'h090;
    @(negedge clk);
    wrStart = 0;
    byteValid = 1; byteData = 8'h99;
    @(negedge clk);
    byteValid = 0;
    deselect = 1;
    @(negedge clk);
    deselect = 0;
    rdReq = 1; rdAddr = 9'h088;
    @(negedge clk);
    rdReq = 0;
    check("R10 read blocked while busy", rdValid, 0);
    busyCnt = 4;
    while (busy && busyCnt < W + 5) begin
      busyCnt++;
      if (busyCnt == W) rdReq = 1;
      @(negedge clk);
      if (busyCnt == W) begin
        rdReq = 0;
        check("R10 read on last busy clock", rdValid, 0);
        busyCnt++;
      end
    end
    check("R9 cycle length unchanged", busyCnt, W + 1);
    check("R8 done", done, 1);
    rdReq = 1; rdAddr = 9'h089;
    @(negedge clk);
    rdReq = 0;
    check("R10 read in done clock", rdValid, 1);
    check("R10 data", rdData, 8'h22);
    @(negedge clk);
    check("R9 no restart", busy, 0);
    pageCheck(5'h09, "R9 bytes during busy dropped");

    // Randomised commands
    for (int it = 0; it < 8; it++) begin
      logic [8:0] a;
      bit al, ok, mg;
      a  = 9'($urandom());
      n  = 1 + ($urandom() % 20);
      al = ($urandom() % 4) != 0;
      ok = ($urandom() % 4) != 0;
      mg = $urandom() % 2;
      startCmd(a);
      for (int k = 0; k < n; k++) sendByte(8'($urandom()));
      finishCmd(al, ok, mg, 8'($urandom()), "R5 R6 R7 random");
      pageCheck(a[8:4], "R2 R3 R4 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule